// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block turns single requests from a 16-bit processor core into bus cycles on a local bus with a 20-bit address. The address goes out on a dedicated address bus and also on a shared address/data (mux) bus. Each cycle runs through four states. In T1 the mux bus carries the low address bits. In T2, T3 and T4 it carries data. Between T3 and T4 the controller adds wait states for as long as a synchronous ready input is low. A 3-bit status code tells external logic what kind of cycle is running. Read, write and data-enable strobes are active low. The block also gives a byte-high enable, separate write strobes for the high and low byte, and a transmit-direction pin.

Another bus master can take the bus through a hold request. The request is granted only between cycles. While the grant is active, every bus output is released and the chip selects are forced inactive. Bus outputs go through pad enables: `bus_oe_o` covers the address, status and strobe pins, and `mux_oe_o` covers the mux bus. The core keeps `req_i` and its fields steady until it sees `done_o`. It then drops or changes them before the next clock edge.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: After reset, the following hold: `stat_o` is 3'b111, `rd_n_o`, `wr_n_o` and `data_en_n_o` are 1, `hold_ack_o` and `done_o` are 0, `bus_oe_o` is 1 and `mux_oe_o` is 0.
- R2: `stat_o` equals `cyc_i` during T1, T2, T3 and every wait state. It is 3'b111 in T4 and in idle. The codes are: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write.
- R3: A request seen at a clock edge while idle, with no hold request, starts T1 in the next cycle. With ready high, `done_o` is high for exactly one cycle, in T4, which is the fourth cycle of the bus cycle. Idle follows.
- R4: `addr_o` shows the full address from the start of T1 until the cycle ends. The mux bus drives address bits 15:0 in T1. Every change on the mux bus and its enable takes effect on the falling clock edge, half a period after the address bus changes.
- R5: For writes (codes 010 and 110), `xmit_o` is 1 from T1 through T4. The mux bus drives the write data from T2 through T4. `wr_n_o` and `data_en_n_o` are 0 in T2, T3 and wait states, and `rd_n_o` stays 1.
- R6: For reads (codes 000, 001, 100 and 101), `xmit_o` is 0 and the mux bus is released after T1. `rd_n_o` and `data_en_n_o` are 0 in T2, T3 and wait states. The mux input sampled at the edge that ends the last T3 or wait state appears on `rdata_o` while `done_o` is high.
- R7: `hi_byte_n_o` is the inverse of `hi_byte_i` from T1 through T4, and 1 when idle. `wr_hi_n_o` is 0 only when `wr_n_o` and `hi_byte_n_o` are both 0. `wr_lo_n_o` is 0 only when `wr_n_o` is 0 and address bit 0 is 0.
- R8: `ready_i` low at the edge ending T3 or a wait state adds one more wait state. Each wait state keeps the status, strobes and direction unchanged, and delays `done_o` by one cycle.
- R9: A hold request is granted only at the edge ending idle or T4. It beats a request that is pending in idle. A hold request raised mid-cycle waits until the cycle completes.
- R10: While `hold_ack_o` is 1, `bus_oe_o` and `mux_oe_o` are 0 and `cs_n_o` is all ones. Otherwise `cs_n_o` follows `cs_n_i`.
- R11: When `hold_req_i` is seen low during the hold, `hold_ack_o` drops at that edge and the controller returns to idle. A request still pending then starts T1 on the following edge.
- R12: A halt cycle (code 011) steps through T1 to T4 with its status but keeps `rd_n_o`, `wr_n_o` and `data_en_n_o` at 1 and never enables the mux bus after T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request, held until done |
| cyc_i | input | 3 | Cycle type code |
| addr_i | input | 20 | Request address |
| hi_byte_i | input | 1 | Request touches the high byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with done |
| done_o | output | 1 | Cycle complete (T4) |
| ready_i | input | 1 | Synchronous ready, active high |
| hold_req_i | input | 1 | Bus request from another master |
| hold_ack_o | output | 1 | Bus granted to the other master |
| cs_n_i | input | 4 | Chip selects from the decoder |
| cs_n_o | output | 4 | Chip selects to the pins |
| bus_oe_o | output | 1 | Pad enable for address, status and strobes |
| addr_o | output | 20 | Address bus |
| mux_o | output | 16 | Mux bus output value |
| mux_oe_o | output | 1 | Mux bus pad enable |
| mux_i | input | 16 | Mux bus pad input |
| stat_o | output | 3 | Cycle status code |
| rd_n_o | output | 1 | Read strobe |
| wr_n_o | output | 1 | Write strobe |
| data_en_n_o | output | 1 | Data transceiver enable |
| hi_byte_n_o | output | 1 | Byte-high enable |
| wr_hi_n_o | output | 1 | High byte write strobe |
| wr_lo_n_o | output | 1 | Low byte write strobe |
| xmit_o | output | 1 | Direction, 1 = controller drives data |

## Verification
A hold request and a pending core request can land on the same idle edge. A hold request can also rise while a cycle is in flight, so that the grant would collide with the T4 completion. The bench raises both hold and request in one idle cycle and expects the grant first and T1 only after release. It also raises hold during T2 and expects the status to continue through T3, `done_o` in T4 and the grant only in the cycle after. Ready held low at the T3 boundary is checked in the same way: the strobes and status must stay frozen until the delayed `done_o`.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  typedef enum logic [2:0] {
    CYC_INTA  = 3'b000,
    CYC_IORD  = 3'b001,
    CYC_IOWR  = 3'b010,
    CYC_HALT  = 3'b011,
    CYC_FETCH = 3'b100,
    CYC_MRD   = 3'b101,
    CYC_MWR   = 3'b110,
    CYC_IDLE  = 3'b111
  } cyc_e;

  typedef enum logic [2:0] {
    ST_TI, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_TH
  } bus_st_e;

  function automatic logic cyc_is_wr(cyc_e c);
    return (c == CYC_IOWR) || (c == CYC_MWR);
  endfunction

  function automatic logic cyc_is_rd(cyc_e c);
    return (c == CYC_INTA) || (c == CYC_IORD) || (c == CYC_FETCH) || (c == CYC_MRD);
  endfunction
endpackage

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hi_byte_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic              hold_req_i,
  input  logic [DATA_W-1:0] mux_i,
  output bus_st_e           state_o,
  output cyc_e              cyc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              hi_byte_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  bus_st_e state_q, state_d;
  logic    take;

  assign take = (state_q == ST_TI) && !hold_req_i && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TI:   state_d = hold_req_i ? ST_TH : (req_i ? ST_T1 : ST_TI);
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = hold_req_i ? ST_TH : ST_TI;
      ST_TH:   state_d = hold_req_i ? ST_TH : ST_TI;
      default: state_d = ST_TI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_TI;
      cyc_o     <= CYC_IDLE;
      addr_o    <= '0;
      hi_byte_o <= 1'b0;
      wdata_o   <= '0;
      rdata_o   <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        cyc_o     <= cyc_e'(cyc_i);
        addr_o    <= addr_i;
        hi_byte_o <= hi_byte_i;
        wdata_o   <= wdata_i;
      end
      // capture on the edge that leaves the data phase
      if ((state_q == ST_T3 || state_q == ST_TW) && ready_i && cyc_is_rd(cyc_o))
        rdata_o <= mux_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lbus_mux_phase.sv
module lbus_mux_phase
  import lbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_st_e           state_i,
  input  cyc_e              cyc_i,
  input  logic [DATA_W-1:0] addr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mux_o,
  output logic              mux_oe_o
);
  // launched on the falling edge: trails the address bus by half a period
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_o    <= '0;
      mux_oe_o <= 1'b0;
    end else begin
      unique case (state_i)
        ST_T1: begin
          mux_o    <= addr_lo_i;
          mux_oe_o <= 1'b1;
        end
        ST_T2, ST_T3, ST_TW, ST_T4: begin
          mux_o    <= wdata_i;
          mux_oe_o <= cyc_is_wr(cyc_i);
        end
        default: mux_oe_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lbus_pins.sv
module lbus_pins
  import lbus_pkg::*;
#(
  parameter int CS_W = 4
) (
  input  bus_st_e         state_i,
  input  cyc_e            cyc_i,
  input  logic            hi_byte_i,
  input  logic            addr0_i,
  input  logic [CS_W-1:0] cs_n_i,
  output logic            hold_ack_o,
  output logic [CS_W-1:0] cs_n_o,
  output logic [2:0]      stat_o,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output logic            data_en_n_o,
  output logic            hi_byte_n_o,
  output logic            wr_hi_n_o,
  output logic            wr_lo_n_o,
  output logic            xmit_o
);
  logic in_cyc, strobe_ph, cmd_ph;

  always_comb begin
    in_cyc    = (state_i == ST_T1) || (state_i == ST_T2) || (state_i == ST_T3) ||
                (state_i == ST_TW) || (state_i == ST_T4);
    strobe_ph = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
    cmd_ph    = in_cyc && (state_i != ST_T4);
    hold_ack_o  = (state_i == ST_TH);
    cs_n_o      = hold_ack_o ? '1 : cs_n_i;
    stat_o      = cmd_ph ? cyc_i : CYC_IDLE;
    rd_n_o      = !(strobe_ph && cyc_is_rd(cyc_i));
    wr_n_o      = !(strobe_ph && cyc_is_wr(cyc_i));
    data_en_n_o = rd_n_o && wr_n_o;
    hi_byte_n_o = !(in_cyc && hi_byte_i);
    wr_hi_n_o   = hi_byte_n_o || wr_n_o;
    wr_lo_n_o   = addr0_i || wr_n_o;
    xmit_o      = in_cyc && cyc_is_wr(cyc_i);
  end
endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CS_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hi_byte_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  input  logic              ready_i,
  input  logic              hold_req_i,
  output logic              hold_ack_o,
  input  logic [CS_W-1:0]   cs_n_i,
  output logic [CS_W-1:0]   cs_n_o,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              mux_oe_o,
  input  logic [DATA_W-1:0] mux_i,
  output logic [2:0]        stat_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              data_en_n_o,
  output logic              hi_byte_n_o,
  output logic              wr_hi_n_o,
  output logic              wr_lo_n_o,
  output logic              xmit_o
);
  bus_st_e           state;
  cyc_e              cyc_q;
  logic              hi_q;
  logic [DATA_W-1:0] wdata_q;
  logic              mux_oe_raw;

  lbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .cyc_i, .addr_i, .hi_byte_i, .wdata_i,
    .ready_i, .hold_req_i, .mux_i,
    .state_o   (state),
    .cyc_o     (cyc_q),
    .addr_o    (addr_o),
    .hi_byte_o (hi_q),
    .wdata_o   (wdata_q),
    .rdata_o   (rdata_o)
  );

  lbus_mux_phase #(.DATA_W(DATA_W)) u_mux (
    .clk_i, .rst_ni,
    .state_i   (state),
    .cyc_i     (cyc_q),
    .addr_lo_i (addr_o[DATA_W-1:0]),
    .wdata_i   (wdata_q),
    .mux_o     (mux_o),
    .mux_oe_o  (mux_oe_raw)
  );

  lbus_pins #(.CS_W(CS_W)) u_pins (
    .state_i   (state),
    .cyc_i     (cyc_q),
    .hi_byte_i (hi_q),
    .addr0_i   (addr_o[0]),
    .cs_n_i, .hold_ack_o, .cs_n_o, .stat_o, .rd_n_o, .wr_n_o,
    .data_en_n_o, .hi_byte_n_o, .wr_hi_n_o, .wr_lo_n_o, .xmit_o
  );

  assign done_o   = (state == ST_T4);
  assign bus_oe_o = !hold_ack_o;
  assign mux_oe_o = mux_oe_raw && !hold_ack_o;
endmodule

// File: rtl/lbus_cycle_ctrl_chk.sv
module lbus_cycle_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold_req_i,
  input logic       ready_i,
  input logic       hold_ack_o,
  input logic [2:0] stat_o,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic       done_o
);
  assert_grant_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(stat_o) == 3'b111);

  assert_release_on_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_ack_o) |-> !$past(hold_req_i));

  assert_rd_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ack_o && !rd_n_o && !ready_i && $past(!rd_n_o)) |=> !rd_n_o);

  assert_wr_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ack_o && !wr_n_o && !ready_i && $past(!wr_n_o)) |=> !wr_n_o);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_n_o || wr_n_o);

  assert_done_passive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> stat_o == 3'b111);

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind lbus_cycle_ctrl lbus_cycle_ctrl_chk u_chk (.*);

// File: tb/lbus_cycle_ctrl_test.sv
`timescale 1ns/1ps
module lbus_cycle_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  cyc_i = 3'b111;
  logic [19:0] addr_i = '0;
  logic        hi_byte_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        done_o;
  logic        ready_i = 1'b1;
  logic        hold_req_i = 1'b0;
  logic        hold_ack_o;
  logic [3:0]  cs_n_i = 4'b0101;
  logic [3:0]  cs_n_o;
  logic        bus_oe_o;
  logic [19:0] addr_o;
  logic [15:0] mux_o;
  logic        mux_oe_o;
  logic [15:0] mux_i = '0;
  logic [2:0]  stat_o;
  logic        rd_n_o, wr_n_o, data_en_n_o, hi_byte_n_o, wr_hi_n_o, wr_lo_n_o, xmit_o;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  lbus_cycle_ctrl uut (
    .clk_i(clk), .rst_ni, .req_i, .cyc_i, .addr_i, .hi_byte_i, .wdata_i, .rdata_o,
    .done_o, .ready_i, .hold_req_i, .hold_ack_o, .cs_n_i, .cs_n_o, .bus_oe_o,
    .addr_o, .mux_o, .mux_oe_o, .mux_i, .stat_o, .rd_n_o, .wr_n_o, .data_en_n_o,
    .hi_byte_n_o, .wr_hi_n_o, .wr_lo_n_o, .xmit_o
  );

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic step();  // next sample point, 3 ns after the rising edge
    @(posedge clk);
    #3;
  endtask

  function automatic logic is_rd(logic [2:0] c);
    return c == 3'b000 || c == 3'b001 || c == 3'b100 || c == 3'b101;
  endfunction

  function automatic logic is_wr(logic [2:0] c);
    return c == 3'b010 || c == 3'b110;
  endfunction

  // One full cycle from an idle sample point back to idle.
  task automatic run_cycle(string tag, logic [2:0] c, logic [19:0] a, logic hi,
                           logic [15:0] wd, logic [15:0] rd, int waits);
    logic r = is_rd(c);
    logic w = is_wr(c);
    req_i = 1'b1; cyc_i = c; addr_i = a; hi_byte_i = hi; wdata_i = wd;
    mux_i = ~rd; ready_i = 1'b1;
    @(posedge clk); #1;  // T1, first half
    chk("R4", "addr in T1", addr_o, a);
    chk("R4", "mux oe before fall", mux_oe_o, 0);
    #2;                  // T1, second half
    chk("R4", "mux oe T1", mux_oe_o, 1);
    chk("R4", "mux addr T1", mux_o, a[15:0]);
    chk("R2", "status T1", stat_o, c);
    chk(tag, "xmit T1", xmit_o, w);
    step();              // T2
    chk(tag, "rd_n T2", rd_n_o, !r);
    chk(tag, "wr_n T2", wr_n_o, !w);
    chk(tag, "den_n T2", data_en_n_o, !(r || w));
    chk(tag, "mux oe T2", mux_oe_o, w);
    if (w) chk("R5", "write data T2", mux_o, wd);
    chk("R7", "hi byte T2", hi_byte_n_o, !hi);
    chk("R7", "wr hi T2", wr_hi_n_o, !(w && hi));
    chk("R7", "wr lo T2", wr_lo_n_o, !(w && !a[0]));
    step();              // T3
    chk("R2", "status T3", stat_o, c);
    ready_i = (waits == 0);
    if (waits == 0) mux_i = rd;
    for (int k = 1; k <= waits; k++) begin
      step();            // Tw
      chk("R8", "status Tw", stat_o, c);
      chk("R8", "rd_n Tw", rd_n_o, !r);
      chk("R8", "wr_n Tw", wr_n_o, !w);
      chk("R8", "xmit Tw", xmit_o, w);
      chk("R8", "no done Tw", done_o, 0);
      ready_i = (k == waits);
      if (k == waits) mux_i = rd;
    end
    step();              // T4
    chk("R3", "done T4", done_o, 1);
    chk("R2", "status T4", stat_o, 3'b111);
    chk(tag, "strobes off T4", {rd_n_o, wr_n_o}, 2'b11);
    if (r) chk("R6", "read data", rdata_o, rd);
    if (w) chk("R5", "data held T4", mux_o, wd);
    chk("R7", "hi byte T4", hi_byte_n_o, !hi);
    req_i = 1'b0; ready_i = 1'b1;
    step();              // Ti
    chk("R3", "done drops", done_o, 0);
    chk("R2", "status idle", stat_o, 3'b111);
    chk("R5", "xmit idle", xmit_o, 0);
  endtask

  task automatic t_reset();
    chk("R1", "status", stat_o, 3'b111);
    chk("R1", "strobes", {rd_n_o, wr_n_o, data_en_n_o}, 3'b111);
    chk("R1", "hold ack/done", {hold_ack_o, done_o}, 2'b00);
    chk("R1", "pad enables", {bus_oe_o, mux_oe_o}, 2'b10);
  endtask

  task automatic t_mem_write();  run_cycle("R5", 3'b110, 20'hA5432, 1'b1, 16'hBEEF, 16'h0, 0); endtask
  task automatic t_io_read();    run_cycle("R6", 3'b001, 20'h00310, 1'b1, 16'h0, 16'h1234, 0); endtask
  task automatic t_fetch_wait(); run_cycle("R6", 3'b100, 20'hFFFF0, 1'b1, 16'h0, 16'hC0DE, 3); endtask
  task automatic t_write_wait(); run_cycle("R5", 3'b010, 20'h00081, 1'b0, 16'h5A5A, 16'h0, 2); endtask
  task automatic t_inta();       run_cycle("R6", 3'b000, 20'h00000, 1'b0, 16'h0, 16'h0042, 0); endtask
  task automatic t_halt();       run_cycle("R12", 3'b011, 20'h12345, 1'b0, 16'h0, 16'h0, 0); endtask

  task automatic t_byte_strobes();
    run_cycle("R7", 3'b110, 20'h40001, 1'b1, 16'h1100, 16'h0, 0);  // odd high byte
    run_cycle("R7", 3'b110, 20'h40002, 1'b0, 16'h0022, 16'h0, 0);  // even low byte
    run_cycle("R7", 3'b101, 20'h40004, 1'b1, 16'h0, 16'h7788, 1);  // word read, no writes
  endtask

  task automatic t_hold_idle();
    cs_n_i = 4'b0101;
    hold_req_i = 1'b1;
    step();
    chk("R9", "grant from idle", hold_ack_o, 1);
    chk("R10", "bus released", {bus_oe_o, mux_oe_o}, 2'b00);
    chk("R10", "cs forced high", cs_n_o, 4'b1111);
    step();
    chk("R10", "still granted", hold_ack_o, 1);
    hold_req_i = 1'b0;
    step();
    chk("R11", "grant dropped", hold_ack_o, 0);
    chk("R10", "cs follow", cs_n_o, 4'b0101);
    chk("R11", "bus back", bus_oe_o, 1);
    chk("R11", "idle status", stat_o, 3'b111);
  endtask

  task automatic t_hold_mid();
    req_i = 1'b1; cyc_i = 3'b110; addr_i = 20'h00200; hi_byte_i = 1'b1; wdata_i = 16'h0F0F;
    step();              // T1
    step();              // T2
    hold_req_i = 1'b1;
    step();              // T3
    chk("R9", "no grant mid cycle", hold_ack_o, 0);
    chk("R9", "cycle continues", stat_o, 3'b110);
    step();              // T4
    chk("R9", "cycle completes", done_o, 1);
    chk("R9", "no grant in T4", hold_ack_o, 0);
    req_i = 1'b0;
    step();
    chk("R9", "grant after T4", hold_ack_o, 1);
    chk("R10", "cs high in hold", cs_n_o, 4'b1111);
    hold_req_i = 1'b0;
    step();
    chk("R11", "release", hold_ack_o, 0);
  endtask

  task automatic t_hold_vs_req();
    hold_req_i = 1'b1;
    req_i = 1'b1; cyc_i = 3'b101; addr_i = 20'h0ABCD; hi_byte_i = 1'b1; mux_i = 16'h9999;
    step();
    chk("R9", "hold beats request", hold_ack_o, 1);
    chk("R10", "mux released", mux_oe_o, 0);
    step();
    chk("R9", "no cycle in hold", done_o, 0);
    hold_req_i = 1'b0;
    step();
    chk("R11", "idle after release", {hold_ack_o, stat_o}, {1'b0, 3'b111});
    step();
    chk("R11", "pending request starts", stat_o, 3'b101);
    chk("R11", "address out", addr_o, 20'h0ABCD);
    step(); step(); step();  // T2, T3, T4
    chk("R11", "done after resume", done_o, 1);
    chk("R6", "read after resume", rdata_o, 16'h9999);
    req_i = 1'b0;
    step();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset();  // checked while reset is held
    #10;
    rst_ni = 1'b1;
    step();
    t_reset();
    t_mem_write();
    t_io_read();
    t_fetch_wait();
    t_write_wait();
    t_inta();
    t_halt();
    t_byte_strobes();
    t_hold_idle();
    t_hold_mid();
    t_hold_vs_req();
    finish_run();
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule